// File: doc/BRIEF.md
# Multi-Port Controller Register Memory

This block is the host-facing register store of a peripheral controller that serves four ports. It keeps 32 sixteen-bit registers for every port, 128 words in all, and turns I/O commands arriving from a system bus into register writes and reads. A command carries a channel number and a function code. The channel number names the controller and the port. The function code names the register and says whether the host writes or reads it. A write delivers its data with the command itself. A read is answered later with a separate response transfer that returns the stored word together with the requesting channel number.

Each port has a busy input from the operation engine. While a port is busy, every command aimed at it is refused with a negative (retry) response and leaves its registers untouched. Software loads a port's setup registers first and writes the task register last. That final write raises a one-cycle start pulse for the port. Only one read response can be waiting at a time. A read that arrives while an earlier response is still held back is refused.

Top module: `mpc_regfile`

## Requirements
- R1: After reset every register reads as zero, and `cmd_ack`, `cmd_nak`, `op_start` and `rsp_valid` are low.
- R2: The word address is the port field `cmd_chan[2:1]` as the upper bits joined with the register field `cmd_func[5:1]`. The same register index on different ports names different words.
- R3: A command whose identifier field `cmd_chan[9:3]` differs from `strap_id` is ignored. It gives no acknowledge, no refusal, no start and no response, and it changes no register.
- R4: An accepted write (`cmd_func[0]` = 1) stores `cmd_data` in the addressed register, and `cmd_ack` is high for one cycle in the cycle after the command.
- R5: An accepted read (`cmd_func[0]` = 0) raises `cmd_ack` in the cycle after the command. In that same cycle `rsp_valid` rises with the stored word on `rsp_data` and the command's channel number on `rsp_chan`. The response is held unchanged until a cycle with `rsp_ready` high.
- R6: A matching command whose port has `port_busy` high is refused. `cmd_nak` is high in the next cycle, no register changes, and no start or response follows.
- R7: An accepted write to register index 31 (the task register) of a port sets that port's bit of `op_start` for exactly the next cycle. At most one start bit is ever high.
- R8: A matching read that arrives while a response is valid and `rsp_ready` is low is refused with `cmd_nak`, and the held response is kept.
- R9: The direction bit `cmd_chan[0]` does not affect which register is addressed.
- R10: `cmd_ack` and `cmd_nak` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_id | input | 7 | Controller identifier set by strap |
| cmd_valid | input | 1 | A command is on the bus this cycle |
| cmd_chan | input | 10 | Channel number: identifier [9:3], port [2:1], direction [0] |
| cmd_func | input | 6 | Function code: register index [5:1], write flag [0] |
| cmd_data | input | 16 | Write data |
| port_busy | input | 4 | Per-port busy from the operation engine |
| rsp_ready | input | 1 | Host takes the pending read response |
| cmd_ack | output | 1 | Command accepted (one cycle after it) |
| cmd_nak | output | 1 | Command refused, retry (one cycle after it) |
| op_start | output | 4 | One-cycle start pulse per port |
| rsp_valid | output | 1 | A read response is pending |
| rsp_chan | output | 10 | Channel number of the answered read |
| rsp_data | output | 16 | Returned register word |

## Verification
The assertions assume that `cmd_valid` is low while reset is applied, so their one-cycle look-backs never see a command from before reset. They also assume the response is held only by `rsp_ready` and by nothing outside the block. The bench drives every input half a cycle away from the clock edge and keeps `cmd_valid` low during reset. Its random phase mixes idle cycles, foreign identifiers, busy ports and a withheld `rsp_ready`. These are the same conditions the properties were written for, so the random stimulus stays inside them.

// File: rtl/mpc_pkg.sv
// Package: shared defaults for the multi-port controller register memory.
// Assumes: widths below are the protocol defaults; modules take them as
// parameter defaults and derive everything else locally.
package mpc_pkg;
    localparam int unsigned PORTS_DEF    = 4;
    localparam int unsigned REGS_DEF     = 32;
    localparam int unsigned DATA_W_DEF   = 16;
    localparam int unsigned ID_W_DEF     = 7;
    localparam int unsigned TASK_IDX_DEF = 31;

    // Outcome of one command after decode.
    typedef enum logic [1:0] {
        CMD_IGNORE = 2'd0,
        CMD_ACCEPT = 2'd1,
        CMD_REFUSE = 2'd2
    } cmd_outcome_e;
endpackage

// File: rtl/mpc_cmd_decode.sv
// Module: command decoder.
// Splits channel number and function code into port, register and write
// flag, checks the identifier, and decides accept or refuse from the
// port busy vector and the response slot state. Purely combinational.
// Assumes: at most one command per cycle.
module mpc_cmd_decode
    import mpc_pkg::*;
#(
    parameter int unsigned PORTS    = PORTS_DEF,
    parameter int unsigned REGS     = REGS_DEF,
    parameter int unsigned ID_W     = ID_W_DEF,
    parameter int unsigned TASK_IDX = TASK_IDX_DEF,
    localparam int unsigned PW      = $clog2(PORTS),
    localparam int unsigned RW      = $clog2(REGS),
    localparam int unsigned CHW     = ID_W + PW + 1,
    localparam int unsigned FW      = RW + 1
) (
    input  logic              cmd_valid,
    input  logic [CHW-1:0]    cmd_chan,
    input  logic [FW-1:0]     cmd_func,
    input  logic [ID_W-1:0]   strap_id,
    input  logic [PORTS-1:0]  port_busy,
    input  logic              rsp_blocked,
    output cmd_outcome_e      outcome,
    output logic              is_write,
    output logic [PW-1:0]     port_idx,
    output logic [RW-1:0]     reg_idx,
    output logic [PORTS-1:0]  start_vec
);
    logic id_hit;
    logic refuse;

    // Field extraction; the direction bit cmd_chan[0] is not used.
    always_comb begin
        port_idx = cmd_chan[PW:1];
        reg_idx  = cmd_func[FW-1:1];
        is_write = cmd_func[0];
        id_hit   = cmd_valid && (cmd_chan[CHW-1 -: ID_W] == strap_id);
    end

    // Accept/refuse decision: busy port, or read with response slot held.
    always_comb begin
        refuse = port_busy[port_idx] || (!is_write && rsp_blocked);
        if (!id_hit)
            outcome = CMD_IGNORE;
        else if (refuse)
            outcome = CMD_REFUSE;
        else
            outcome = CMD_ACCEPT;
    end

    // Start request: accepted write to the task register of the port.
    always_comb begin
        start_vec = '0;
        if (outcome == CMD_ACCEPT && is_write && reg_idx == RW'(TASK_IDX))
            start_vec[port_idx] = 1'b1;
    end
endmodule

// File: rtl/mpc_reg_bank.sv
// Module: register storage, one bank of REGS words per port.
// One write port and one combinational read port. Reset clears all words.
// Assumes: the write and read addresses are in range (power-of-two sizes).
module mpc_reg_bank
    import mpc_pkg::*;
#(
    parameter int unsigned PORTS  = PORTS_DEF,
    parameter int unsigned REGS   = REGS_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    localparam int unsigned PW    = $clog2(PORTS),
    localparam int unsigned RW    = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_port,
    input  logic [RW-1:0]     wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PW-1:0]     rd_port,
    input  logic [RW-1:0]     rd_reg,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] bank_out [PORTS];

    for (genvar g = 0; g < PORTS; g++) begin : g_bank
        logic [DATA_W-1:0] words [REGS];
        logic              sel;

        // Bank select for this port.
        always_comb sel = wr_en && (wr_port == PW'(g));

        // Word storage with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < REGS; i++)
                    words[i] <= '0;
            end else if (sel) begin
                words[wr_reg] <= wr_data;
            end
        end

        // Per-bank read word.
        always_comb bank_out[g] = words[rd_reg];
    end

    // Port mux for the read word.
    always_comb rd_data = bank_out[rd_port];
endmodule

// File: rtl/mpc_rsp_slot.sv
// Module: single read-response holding register.
// Loads on an accepted read and holds until the host signals ready.
// Assumes: load is only asserted when the slot is free or being emptied.
module mpc_rsp_slot
    import mpc_pkg::*;
#(
    parameter int unsigned CHW    = 10,
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHW-1:0]    load_chan,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [CHW-1:0]    rsp_chan,
    output logic [DATA_W-1:0] rsp_data,
    output logic              blocked
);
    // Slot occupancy and payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_chan  <= '0;
            rsp_data  <= '0;
        end else if (load) begin
            rsp_valid <= 1'b1;
            rsp_chan  <= load_chan;
            rsp_data  <= load_data;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    // Slot cannot take a new read this cycle.
    always_comb blocked = rsp_valid && !rsp_ready;
endmodule

// File: rtl/mpc_regfile.sv
// Module: multi-port controller register memory (top).
// Decodes bus commands into register writes and reads, refuses commands
// to busy ports, returns reads through a response slot, and pulses a
// per-port start when the task register is written.
// Assumes: one command per cycle; port_busy comes from the engine.
module mpc_regfile
    import mpc_pkg::*;
#(
    parameter int unsigned PORTS    = PORTS_DEF,
    parameter int unsigned REGS     = REGS_DEF,
    parameter int unsigned DATA_W   = DATA_W_DEF,
    parameter int unsigned ID_W     = ID_W_DEF,
    parameter int unsigned TASK_IDX = TASK_IDX_DEF,
    localparam int unsigned PW      = $clog2(PORTS),
    localparam int unsigned RW      = $clog2(REGS),
    localparam int unsigned CHW     = ID_W + PW + 1,
    localparam int unsigned FW      = RW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   strap_id,
    input  logic              cmd_valid,
    input  logic [CHW-1:0]    cmd_chan,
    input  logic [FW-1:0]     cmd_func,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [PORTS-1:0]  port_busy,
    input  logic              rsp_ready,
    output logic              cmd_ack,
    output logic              cmd_nak,
    output logic [PORTS-1:0]  op_start,
    output logic              rsp_valid,
    output logic [CHW-1:0]    rsp_chan,
    output logic [DATA_W-1:0] rsp_data
);
    cmd_outcome_e      outcome;
    logic              is_write;
    logic [PW-1:0]     port_idx;
    logic [RW-1:0]     reg_idx;
    logic [PORTS-1:0]  start_vec;
    logic              rsp_blocked;
    logic              accept_wr;
    logic              accept_rd;
    logic [DATA_W-1:0] rd_word;

    mpc_cmd_decode #(
        .PORTS(PORTS), .REGS(REGS), .ID_W(ID_W), .TASK_IDX(TASK_IDX)
    ) u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_chan   (cmd_chan),
        .cmd_func   (cmd_func),
        .strap_id   (strap_id),
        .port_busy  (port_busy),
        .rsp_blocked(rsp_blocked),
        .outcome    (outcome),
        .is_write   (is_write),
        .port_idx   (port_idx),
        .reg_idx    (reg_idx),
        .start_vec  (start_vec)
    );

    // Accepted write / read strobes.
    always_comb begin
        accept_wr = (outcome == CMD_ACCEPT) && is_write;
        accept_rd = (outcome == CMD_ACCEPT) && !is_write;
    end

    mpc_reg_bank #(
        .PORTS(PORTS), .REGS(REGS), .DATA_W(DATA_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept_wr),
        .wr_port(port_idx),
        .wr_reg (reg_idx),
        .wr_data(cmd_data),
        .rd_port(port_idx),
        .rd_reg (reg_idx),
        .rd_data(rd_word)
    );

    mpc_rsp_slot #(
        .CHW(CHW), .DATA_W(DATA_W)
    ) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept_rd),
        .load_chan(cmd_chan),
        .load_data(rd_word),
        .rsp_ready(rsp_ready),
        .rsp_valid(rsp_valid),
        .rsp_chan (rsp_chan),
        .rsp_data (rsp_data),
        .blocked  (rsp_blocked)
    );

    // Registered handshake and start pulses, one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_ack  <= 1'b0;
            cmd_nak  <= 1'b0;
            op_start <= '0;
        end else begin
            cmd_ack  <= (outcome == CMD_ACCEPT);
            cmd_nak  <= (outcome == CMD_REFUSE);
            op_start <= start_vec;
        end
    end
endmodule

// File: rtl/mpc_regfile_chk.sv
// Module: assertion checker for mpc_regfile, attached by bind.
// Assumes: cmd_valid is low while reset is applied.
module mpc_regfile_chk #(
    parameter int unsigned PORTS    = 4,
    parameter int unsigned ID_W     = 7,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned TASK_IDX = 31,
    parameter int unsigned PW       = 2,
    parameter int unsigned CHW      = 10,
    parameter int unsigned FW       = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ID_W-1:0]   strap_id,
    input logic              cmd_valid,
    input logic [CHW-1:0]    cmd_chan,
    input logic [FW-1:0]     cmd_func,
    input logic [PORTS-1:0]  port_busy,
    input logic              rsp_ready,
    input logic              cmd_ack,
    input logic              cmd_nak,
    input logic [PORTS-1:0]  op_start,
    input logic              rsp_valid,
    input logic [CHW-1:0]    rsp_chan,
    input logic [DATA_W-1:0] rsp_data
);
    logic id_hit;
    always_comb id_hit = cmd_valid && (cmd_chan[CHW-1 -: ID_W] == strap_id);

    AST_ACK_NAK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ack && cmd_nak)); // R10

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_start)); // R7

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (id_hit && !(cmd_func[0] && cmd_func[FW-1:1] == (FW-1)'(TASK_IDX)))
        |=> (op_start == '0)); // R7

    AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (id_hit && port_busy[cmd_chan[PW:1]]) |=> (cmd_nak && !cmd_ack && op_start == '0)); // R6

    AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_hit) |=> (!cmd_ack && !cmd_nak && op_start == '0)); // R3

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_chan) && $stable(rsp_data))); // R5

    AST_SLOT_BLOCK_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        (id_hit && !cmd_func[0] && rsp_valid && !rsp_ready) |=> cmd_nak); // R8
endmodule

bind mpc_regfile mpc_regfile_chk #(
    .PORTS(PORTS), .ID_W(ID_W), .DATA_W(DATA_W), .TASK_IDX(TASK_IDX),
    .PW(PW), .CHW(CHW), .FW(FW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_id (strap_id),
    .cmd_valid(cmd_valid),
    .cmd_chan (cmd_chan),
    .cmd_func (cmd_func),
    .port_busy(port_busy),
    .rsp_ready(rsp_ready),
    .cmd_ack  (cmd_ack),
    .cmd_nak  (cmd_nak),
    .op_start (op_start),
    .rsp_valid(rsp_valid),
    .rsp_chan (rsp_chan),
    .rsp_data (rsp_data)
);

// File: tb/mpc_regfile_test.sv
// Bench for mpc_regfile: directed corner cases then seeded random traffic,
// all compared against a bench-side register model.
module mpc_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] MY_ID = 7'h2B;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  strap_id;
    logic        cmd_valid;
    logic [9:0]  cmd_chan;
    logic [5:0]  cmd_func;
    logic [15:0] cmd_data;
    logic [3:0]  port_busy;
    logic        rsp_ready;
    logic        cmd_ack, cmd_nak, rsp_valid;
    logic [3:0]  op_start;
    logic [9:0]  rsp_chan;
    logic [15:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] model [128];
    logic        m_rv;
    logic [9:0]  m_rc;
    logic [15:0] m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpc_regfile uut (
        .clk(clk), .rst_n(rst_n), .strap_id(strap_id),
        .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_func(cmd_func),
        .cmd_data(cmd_data), .port_busy(port_busy), .rsp_ready(rsp_ready),
        .cmd_ack(cmd_ack), .cmd_nak(cmd_nak), .op_start(op_start),
        .rsp_valid(rsp_valid), .rsp_chan(rsp_chan), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] mk_chan(input logic [6:0] id, input int p, input bit dir);
        return {id, 2'(p), dir};
    endfunction

    function automatic logic [5:0] mk_func(input int r, input bit wr);
        return {5'(r), wr};
    endfunction

    // One bus cycle: drive at negedge, predict, sample after posedge.
    task automatic step(input bit v, input logic [9:0] ch, input logic [5:0] fn,
                        input logic [15:0] d, input logic [3:0] busy, input bit rdy);
        bit hit, wr, blk, refuse, accept;
        int p, r;
        logic [3:0] e_start;
        string tag;
        cmd_valid = v; cmd_chan = ch; cmd_func = fn; cmd_data = d;
        port_busy = busy; rsp_ready = rdy;
        hit = v && (ch[9:3] == MY_ID);
        p = int'(ch[2:1]); r = int'(fn[5:1]); wr = fn[0];
        blk = m_rv && !rdy;
        refuse = hit && (busy[p] || (!wr && blk));
        accept = hit && !refuse;
        e_start = (accept && wr && r == 31) ? 4'(1 << p) : 4'h0;
        if (!hit) tag = "R3";
        else if (busy[p]) tag = "R6";
        else if (!wr && blk) tag = "R8";
        else if (wr) tag = "R4";
        else tag = "R5";
        if (accept && !wr) begin
            m_rv = 1'b1; m_rc = ch; m_rd = model[{ch[2:1], fn[5:1]}];
        end else if (rdy) begin
            m_rv = 1'b0;
        end
        if (accept && wr) model[{ch[2:1], fn[5:1]}] = d;
        @(posedge clk); #1;
        chk(cmd_ack == accept, {tag, " ack"}, 32'(cmd_ack), 32'(accept));
        chk(cmd_nak == refuse, {tag, " nak"}, 32'(cmd_nak), 32'(refuse));
        chk(!(cmd_ack && cmd_nak), "R10 ack/nak exclusive", 32'({cmd_ack, cmd_nak}), 32'h0);
        chk(op_start == e_start, "R7 start", 32'(op_start), 32'(e_start));
        chk(rsp_valid == m_rv, "R5 rsp_valid", 32'(rsp_valid), 32'(m_rv));
        if (m_rv && rsp_valid) begin
            chk(rsp_data == m_rd, "R5 rsp_data", 32'(rsp_data), 32'(m_rd));
            chk(rsp_chan == m_rc, "R5 rsp_chan", 32'(rsp_chan), 32'(m_rc));
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, '0, '0, '0, 4'h0, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 128; i++) model[i] = '0;
        m_rv = 0; m_rc = '0; m_rd = '0;
        strap_id = MY_ID; rst_n = 0;
        cmd_valid = 0; cmd_chan = '0; cmd_func = '0; cmd_data = '0;
        port_busy = '0; rsp_ready = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: outputs low after reset
        chk({cmd_ack, cmd_nak, op_start, rsp_valid} == 7'h0, "R1 outputs", 32'({cmd_ack, cmd_nak, op_start, rsp_valid}), 32'h0);
        // R1: registers read zero
        for (int p = 0; p < 4; p++) begin
            step(1, mk_chan(MY_ID, p, 0), mk_func(p * 7 + 3, 0), '0, 4'h0, 1);
            chk(rsp_data == 16'h0, "R1 reset word", 32'(rsp_data), 32'h0);
        end
        // R4/R2: same index on two ports
        step(1, mk_chan(MY_ID, 0, 1), mk_func(5, 1), 16'hA5A5, 4'h0, 1);
        step(1, mk_chan(MY_ID, 3, 1), mk_func(5, 1), 16'h1234, 4'h0, 1);
        step(1, mk_chan(MY_ID, 0, 0), mk_func(5, 0), '0, 4'h0, 1);
        chk(rsp_data == 16'hA5A5, "R2 port0 reg5", 32'(rsp_data), 32'hA5A5);
        step(1, mk_chan(MY_ID, 3, 0), mk_func(5, 0), '0, 4'h0, 1);
        chk(rsp_data == 16'h1234, "R2 port3 reg5", 32'(rsp_data), 32'h1234);
        // R9: direction bit ignored
        step(1, mk_chan(MY_ID, 3, 1), mk_func(5, 0), '0, 4'h0, 1);
        chk(rsp_data == 16'h1234, "R9 dir bit", 32'(rsp_data), 32'h1234);
        // R3: foreign id write leaves register unchanged
        step(1, mk_chan(MY_ID ^ 7'h01, 0, 1), mk_func(5, 1), 16'hDEAD, 4'h0, 1);
        step(1, mk_chan(MY_ID, 0, 0), mk_func(5, 0), '0, 4'h0, 1);
        chk(rsp_data == 16'hA5A5, "R3 foreign write ignored", 32'(rsp_data), 32'hA5A5);
        // R6: busy port refuses write and read
        step(1, mk_chan(MY_ID, 0, 1), mk_func(5, 1), 16'hBEEF, 4'h1, 1);
        step(1, mk_chan(MY_ID, 0, 0), mk_func(5, 0), '0, 4'h1, 1);
        step(1, mk_chan(MY_ID, 0, 0), mk_func(5, 0), '0, 4'h0, 1);
        chk(rsp_data == 16'hA5A5, "R6 busy write dropped", 32'(rsp_data), 32'hA5A5);
        // R7: task register write starts port 2; busy port 1 gets no start
        step(1, mk_chan(MY_ID, 2, 1), mk_func(31, 1), 16'h0042, 4'h0, 1);
        step(1, mk_chan(MY_ID, 1, 1), mk_func(31, 1), 16'h0042, 4'h2, 1);
        step(1, mk_chan(MY_ID, 1, 1), mk_func(30, 1), 16'h0042, 4'h0, 1);
        // R8: held response blocks a second read
        step(1, mk_chan(MY_ID, 3, 0), mk_func(5, 0), '0, 4'h0, 0);
        step(1, mk_chan(MY_ID, 0, 0), mk_func(5, 0), '0, 4'h0, 0);
        chk(rsp_data == 16'h1234, "R8 held response kept", 32'(rsp_data), 32'h1234);
        idle();
        idle();
        // Random traffic
        for (int n = 0; n < 1500; n++) begin
            logic [6:0] id;
            id = ($urandom % 8 == 0) ? 7'($urandom) : MY_ID;
            step(($urandom % 5) != 0,
                 mk_chan(id, int'($urandom % 4), 1'($urandom)),
                 mk_func(($urandom % 4 == 0) ? 31 : int'($urandom % 32), 1'($urandom)),
                 16'($urandom),
                 4'($urandom & $urandom),
                 ($urandom % 4) != 0);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule